// File: doc/BRIEF.md
# Atomic Register-Memory Exchange Unit

This execution unit swaps two operands. It accepts one decoded micro-operation at a time. The operation names either two registers or one register and a memory location. It also carries an operand size, a 64-bit promotion bit, a register-extension bit per register operand, a lock-prefix bit and a flag for the single-byte accumulator-exchange encoding. The unit reads and writes an external 16-entry, 64-bit register file through two combinational read ports and two write ports.

A register-register swap completes in the cycle it is accepted, and both registers are written at the next clock edge. A register-memory swap runs as a locked sequence: one cycle with only the lock raised, a read, a write of the register value, and then the register update. The bus lock stays raised whether or not the lock-prefix bit is set, and it falls only after the memory write is acknowledged. While this sequence runs, `busy` is high and new operations are ignored.

Top module: `xchg_unit`

## Requirements
- R1: An accepted register-register exchange (`op_mem`=0, `op_short90`=0) pulses `done` in its accept cycle. At the following edge, register A receives the old value of B and register B receives the old value of A, each merged by R5/R6.
- R2: An accepted memory exchange (`op_mem`=1) raises `busy`. It then issues one read of `op_addr` followed by one write of register A's value to `op_addr`. In the cycle the write is acknowledged, `done` pulses and register A receives the old memory value, merged by R5/R6.
- R3: For a memory exchange, `bus_lock` is high from the cycle after acceptance through the write-acknowledge cycle, for either value of `op_lock`. It is low in the cycle after that. `mem_req` is never high without `bus_lock`.
- R4: A register-register exchange or a no-op never raises `bus_lock`, even with `op_lock`=1.
- R5: `op_size` encodes 0 = 8-bit, 1 = 16-bit, and 2 or 3 = 32-bit. For 8-bit and 16-bit sizes only the low 1 or 2 bytes of a destination register change, and its upper bits are kept.
- R6: A 32-bit register write places the low 32 bits of the source and clears bits 63:32.
- R7: `op_promote`=1 with `op_size` 2 or 3 makes the exchange 64-bit. With `op_size` 0 or 1 the promotion bit has no effect.
- R8: `op_short90`=1 with `op_mem`=0 is a no-op. `done` pulses, and no register is written, even with `op_promote`=1. A normal 32-bit exchange of register 0 with itself still clears bits 63:32.
- R9: The register index is {ext, reg}, so an extension bit of 1 selects registers 8 to 15.
- R10: An `op_valid` presented while `busy` is high is ignored. It writes no register and causes no `done`.
- R11: A memory write drives `mem_size` with the effective size code (0 = 8, 1 = 16, 2 = 32, 3 = 64). `mem_wdata` carries zeros above the selected bytes, and memory bytes above that size are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_mem | input | 1 | Second operand is memory |
| op_reg_a | input | 3 | Register A base index |
| op_ext_a | input | 1 | Register A extension bit |
| op_reg_b | input | 3 | Register B base index (register form) |
| op_ext_b | input | 1 | Register B extension bit |
| op_size | input | 2 | Operand size code |
| op_promote | input | 1 | 64-bit promotion |
| op_lock | input | 1 | Lock prefix present |
| op_short90 | input | 1 | Single-byte accumulator exchange form |
| op_addr | input | AW | Memory operand address |
| busy | output | 1 | Memory exchange in progress |
| done | output | 1 | Exchange completes this cycle |
| rf_ra_idx | output | 4 | Read port A index |
| rf_ra_data | input | 64 | Read port A data |
| rf_rb_idx | output | 4 | Read port B index |
| rf_rb_data | input | 64 | Read port B data |
| rf_we_a | output | 1 | Write enable A |
| rf_wa_idx | output | 4 | Write index A |
| rf_wa_data | output | 64 | Write data A |
| rf_we_b | output | 1 | Write enable B |
| rf_wb_idx | output | 4 | Write index B |
| rf_wb_data | output | 64 | Write data B |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request acknowledged |
| mem_rdata | input | 64 | Read data, valid with read acknowledge |
| bus_lock | output | 1 | Bus held locked |

## Verification
A wrong sequencer state shows up at the ports within one cycle. It appears as `bus_lock` falling before the write acknowledge, as a read and a write in the wrong order, or as `busy` staying high so later operations are ignored. A lost or stale captured read value, or a wrong latched size, only shows once the final register write lands. The checks therefore compare the whole register file and memory after every operation. Stray operations are driven while `busy` is high, so any leak out of the idle state damages a register the checks will read.

// File: rtl/xchg_unit.sv
module xchg_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_mem,
  input  logic [2:0]    op_reg_a,
  input  logic          op_ext_a,
  input  logic [2:0]    op_reg_b,
  input  logic          op_ext_b,
  input  logic [1:0]    op_size,
  input  logic          op_promote,
  input  logic          op_lock,
  input  logic          op_short90,
  input  logic [AW-1:0] op_addr,
  output logic          busy,
  output logic          done,
  output logic [3:0]    rf_ra_idx,
  input  logic [63:0]   rf_ra_data,
  output logic [3:0]    rf_rb_idx,
  input  logic [63:0]   rf_rb_data,
  output logic          rf_we_a,
  output logic [3:0]    rf_wa_idx,
  output logic [63:0]   rf_wa_data,
  output logic          rf_we_b,
  output logic [3:0]    rf_wb_idx,
  output logic [63:0]   rf_wb_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [63:0]   mem_rdata,
  output logic          bus_lock
);

  typedef enum logic [1:0] {S_IDLE, S_LOCK, S_RD, S_WR} st_t;

  st_t           st;
  logic [3:0]    r_a;
  logic [1:0]    r_esz;
  logic [AW-1:0] r_addr;
  logic [63:0]   r_data;
  logic          lock_q;

  function automatic logic [63:0] place(input logic [63:0] old, input logic [63:0] nv,
                                        input logic [1:0] esz);
    case (esz)
      2'd0:    place = {old[63:8], nv[7:0]};
      2'd1:    place = {old[63:16], nv[15:0]};
      2'd2:    place = {32'd0, nv[31:0]};
      default: place = nv;
    endcase
  endfunction

  function automatic logic [63:0] trim(input logic [63:0] v, input logic [1:0] esz);
    case (esz)
      2'd0:    trim = {56'd0, v[7:0]};
      2'd1:    trim = {48'd0, v[15:0]};
      2'd2:    trim = {32'd0, v[31:0]};
      default: trim = v;
    endcase
  endfunction

  logic [1:0] esz_in;
  logic       accept, rr, fin;

  assign esz_in = (op_promote && op_size[1]) ? 2'd3 : (op_size == 2'd3 ? 2'd2 : op_size);
  assign accept = op_valid && (st == S_IDLE);
  assign rr     = accept && !op_mem && !op_short90;
  assign fin    = (st == S_WR) && mem_ack;

  assign busy      = st != S_IDLE;
  assign bus_lock  = lock_q;
  assign done      = (accept && !op_mem) || fin;

  assign rf_ra_idx = (st == S_IDLE) ? {op_ext_a, op_reg_a} : r_a;
  assign rf_rb_idx = {op_ext_b, op_reg_b};

  assign rf_we_a    = rr || fin;
  assign rf_wa_idx  = rf_ra_idx;
  assign rf_wa_data = (st == S_WR) ? place(rf_ra_data, r_data, r_esz)
                                   : place(rf_ra_data, rf_rb_data, esz_in);
  assign rf_we_b    = rr;
  assign rf_wb_idx  = rf_rb_idx;
  assign rf_wb_data = place(rf_rb_data, rf_ra_data, esz_in);

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = st == S_WR;
  assign mem_addr  = r_addr;
  assign mem_size  = r_esz;
  assign mem_wdata = trim(rf_ra_data, r_esz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lock_q <= 1'b0;
      r_a    <= '0;
      r_esz  <= '0;
      r_addr <= '0;
      r_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept && op_mem) begin
          st     <= S_LOCK;
          lock_q <= 1'b1;
          r_a    <= {op_ext_a, op_reg_a};
          r_esz  <= esz_in;
          r_addr <= op_addr;
        end
        S_LOCK: st <= S_RD;
        S_RD: if (mem_ack) begin
          r_data <= mem_rdata;
          st     <= S_WR;
        end
        default: if (mem_ack) begin
          st     <= S_IDLE;
          lock_q <= 1'b0;
        end
      endcase
    end
  end

  // R3
  req_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_lock);

  // R3
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(mem_req && mem_we && mem_ack));

  // R4
  rr_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && !op_mem && op_lock) |=> !bus_lock);

  // R8
  nop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && !op_mem && op_short90) |-> (!rf_we_a && !rf_we_b));

  // R6
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_a && busy && mem_size == 2'd2) |-> rf_wa_data[63:32] == 32'd0);

  // R10
  busy_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rf_we_b);

  // R11
  wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_size == 2'd0) |-> mem_wdata[63:8] == 56'd0);

endmodule

// File: tb/test_xchg_unit.sv
module test_xchg_unit;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          op_valid = 0, op_mem = 0, op_ext_a = 0, op_ext_b = 0;
  logic [2:0]    op_reg_a = 0, op_reg_b = 0;
  logic [1:0]    op_size = 0;
  logic          op_promote = 0, op_lock = 0, op_short90 = 0;
  logic [AW-1:0] op_addr = 0;
  logic          busy, done, rf_we_a, rf_we_b, mem_req, mem_we, mem_ack, bus_lock;
  logic [3:0]    rf_ra_idx, rf_rb_idx, rf_wa_idx, rf_wb_idx;
  logic [63:0]   rf_ra_data, rf_rb_data, rf_wa_data, rf_wb_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;

  xchg_unit #(.AW(AW)) i_xchg_unit (.*);

  logic [63:0] rf [16];
  logic [63:0] mem [16];
  logic [63:0] exp_rf [16];
  logic [63:0] exp_mem [16];
  logic [1:0]  wcnt;
  int checks = 0, errors = 0;

  function automatic logic [63:0] seed_val(input int i, input bit m);
    return (64'h9E37_79B9_7F4A_7C15 * (i + 3)) ^ (m ? 64'h0F0F_00FF_F0F0_FF00 : 64'h0);
  endfunction

  function automatic logic [1:0] eff(input logic [1:0] s, input logic p);
    if (p && s >= 2) return 2'd3;
    return (s == 2'd3) ? 2'd2 : s;
  endfunction

  function automatic logic [63:0] reg_put(input logic [63:0] o, input logic [63:0] n,
                                          input logic [1:0] e);
    case (e)
      0: return {o[63:8], n[7:0]};
      1: return {o[63:16], n[15:0]};
      2: return {32'd0, n[31:0]};
      default: return n;
    endcase
  endfunction

  function automatic logic [63:0] mem_put(input logic [63:0] o, input logic [63:0] n,
                                          input logic [1:0] e);
    case (e)
      0: return {o[63:8], n[7:0]};
      1: return {o[63:16], n[15:0]};
      2: return {o[63:32], n[31:0]};
      default: return n;
    endcase
  endfunction

  function automatic logic [63:0] lowpart(input logic [63:0] v, input logic [1:0] e);
    return mem_put(64'd0, v, e);
  endfunction

  assign rf_ra_data = rf[rf_ra_idx];
  assign rf_rb_data = rf[rf_rb_idx];
  assign mem_rdata  = mem[mem_addr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        rf[i]  <= seed_val(i, 0);
        mem[i] <= seed_val(i, 1);
      end
      mem_ack <= 1'b0;
      wcnt    <= 2'd0;
    end else begin
      if (rf_we_b) rf[rf_wb_idx] <= rf_wb_data;
      if (rf_we_a) rf[rf_wa_idx] <= rf_wa_data;
      if (mem_req && mem_we && mem_ack) mem[mem_addr[3:0]] <= mem_put(mem[mem_addr[3:0]], mem_wdata, mem_size);
      if (mem_req && !mem_ack) begin
        if (wcnt == 0) mem_ack <= 1'b1;
        else wcnt <= wcnt - 1;
      end else begin
        mem_ack <= 1'b0;
        wcnt    <= 2'($urandom % 3);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic cmp_state(input string tag);
    bit ok = 1;
    for (int i = 0; i < 16; i++) begin
      if (rf[i] !== exp_rf[i]) begin
        ok = 0;
        chk(0, $sformatf("%s reg%0d", tag, i), rf[i], exp_rf[i]);
      end
      if (mem[i] !== exp_mem[i]) begin
        ok = 0;
        chk(0, $sformatf("%s mem%0d", tag, i), mem[i], exp_mem[i]);
      end
    end
    if (ok) chk(1, tag, 0, 0);
  endtask

  task automatic reg_op(input logic [3:0] a, input logic [3:0] b, input logic [1:0] s,
                        input bit p, input bit lk, input bit nop, input string tag);
    logic [63:0] oa, ob;
    logic [1:0] e;
    @(negedge clk);
    {op_ext_a, op_reg_a} = a; {op_ext_b, op_reg_b} = b;
    op_size = s; op_promote = p; op_lock = lk; op_short90 = nop; op_mem = 0; op_valid = 1;
    #0.5;
    chk(done === 1'b1, {tag, " R1 done in accept cycle"}, done, 1);
    if (nop) chk(!rf_we_a && !rf_we_b, {tag, " R8 no write enable"}, {rf_we_a, rf_we_b}, 0);
    if (!nop) begin
      e = eff(s, p);
      oa = exp_rf[a]; ob = exp_rf[b];
      exp_rf[b] = reg_put(ob, oa, e);
      exp_rf[a] = reg_put(oa, ob, e);
    end
    @(negedge clk);
    op_valid = 0;
    chk(bus_lock === 1'b0 && busy === 1'b0, {tag, " R4 no lock for register form"}, {bus_lock, busy}, 0);
    cmp_state(tag);
  endtask

  task automatic mem_op(input logic [3:0] a, input logic [3:0] ad, input logic [1:0] s,
                        input bit p, input bit lk, input bit intrude, input string tag);
    logic [63:0] r, m;
    logic [1:0] e;
    int n = 0;
    bit lock_ok = 1, wr_seen = 0, rd_seen = 0, order_ok = 1;
    e = eff(s, p);
    r = exp_rf[a]; m = exp_mem[ad];
    @(negedge clk);
    {op_ext_a, op_reg_a} = a; op_addr = AW'(ad);
    op_size = s; op_promote = p; op_lock = lk; op_short90 = 0; op_mem = 1; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
    while (1) begin
      n++;
      if (bus_lock !== 1'b1 || busy !== 1'b1) lock_ok = 0;
      if (mem_req && !mem_we && mem_ack) rd_seen = 1;
      if (mem_req && mem_we) begin
        if (!rd_seen) order_ok = 0;
        if (mem_ack) begin
          wr_seen = 1;
          chk(mem_wdata === lowpart(r, e), {tag, " R11 write data trimmed"}, mem_wdata, lowpart(r, e));
          chk(mem_size === e, {tag, " R11 size code"}, 64'(mem_size), 64'(e));
        end
      end
      if (done === 1'b1) begin
        op_valid = 0;
        break;
      end
      if (n > 40) break;
      if (intrude) begin
        op_valid = 1'($urandom);
        op_mem = 0; op_short90 = 0;
        {op_ext_a, op_reg_a} = 4'($urandom); {op_ext_b, op_reg_b} = 4'($urandom);
        op_size = 2'($urandom);
        if (done !== 1'b0) lock_ok = 0;
      end
      @(negedge clk);
    end
    chk(done === 1'b1 && wr_seen, {tag, " R2 done with write ack"}, {done, wr_seen}, 2'b11);
    chk(order_ok && rd_seen, {tag, " R2 read before write"}, {order_ok, rd_seen}, 2'b11);
    chk(lock_ok, {tag, " R3 R10 lock and busy held, no stray done"}, lock_ok, 1);
    exp_mem[ad] = mem_put(m, r, e);
    exp_rf[a] = reg_put(r, m, e);
    @(negedge clk);
    chk(bus_lock === 1'b0 && busy === 1'b0, {tag, " R3 lock released"}, {bus_lock, busy}, 0);
    cmp_state({tag, " R2 R10"});
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin
      exp_rf[i] = seed_val(i, 0);
      exp_mem[i] = seed_val(i, 1);
    end
    repeat (3) @(negedge clk);
    chk(busy === 0 && bus_lock === 0 && mem_req === 0 && done === 0, "reset idle", {busy, bus_lock, mem_req, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && bus_lock === 0, "after reset idle", {busy, bus_lock}, 0);

    reg_op(4'd1, 4'd2, 2'd0, 0, 0, 0, "R5 8-bit keeps upper");
    reg_op(4'd3, 4'd4, 2'd1, 0, 0, 0, "R5 16-bit keeps upper");
    reg_op(4'd5, 4'd6, 2'd2, 0, 0, 0, "R6 32-bit zero-extends");
    reg_op(4'd6, 4'd7, 2'd3, 0, 0, 0, "R6 size3 is 32-bit");
    reg_op(4'd1, 4'd3, 2'd2, 1, 0, 0, "R7 promote to 64");
    reg_op(4'd2, 4'd4, 2'd0, 1, 0, 0, "R7 promote ignored at 8");
    reg_op(4'd0, 4'd0, 2'd2, 1, 0, 1, "R8 short form no-op with promote");
    reg_op(4'd0, 4'd0, 2'd2, 0, 0, 0, "R8 plain acc self swap clears upper");
    reg_op(4'd9, 4'd15, 2'd3, 1, 0, 0, "R9 extended registers");
    reg_op(4'd8, 4'd1, 2'd1, 0, 1, 0, "R4 lock prefix on register form");
    mem_op(4'd2, 4'd5, 2'd2, 1, 0, 0, "R3 mem 64 without prefix");
    mem_op(4'd12, 4'd6, 2'd0, 0, 1, 0, "R11 mem 8-bit with prefix");
    mem_op(4'd7, 4'd7, 2'd2, 0, 0, 1, "R6 mem 32 with intruders");
    mem_op(4'd3, 4'd1, 2'd1, 0, 0, 1, "R5 mem 16 with intruders");

    for (int k = 0; k < 150; k++) begin
      int sel = $urandom % 10;
      if (sel < 6)
        reg_op(4'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 0, "R1 random register");
      else if (sel < 9)
        mem_op(4'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R2 random memory");
      else
        reg_op(4'd0, 4'd0, 2'($urandom), 1'($urandom), 1'($urandom), 1, "R8 random no-op");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule